// File: doc/BRIEF.md
# Atomic Set/Clear Output Port

This block is a memory-mapped output port of sixteen pins held in one level register. Software can change the pins in three ways. It can write the whole level word directly. It can use a combined set/clear word that raises some pins and lowers others in a single bus write. It can use a clear-only word that lowers pins.

The set/clear and clear-only words act on one clock edge. Software therefore never reads the port, edits the value and writes it back, so no interrupt can slip between a read and the write that follows it. Pins that a write does not name keep their level. This lets separate pieces of software own different pins of the same port.

The bus is a plain register interface with single-cycle writes and combinational read data. It has no handshake and no back-pressure: every write is accepted on the edge where its enable is high, and read data is valid in the same cycle as the read enable. The pin outputs come straight from the level register.

Top module: `pin_drive_port`

## Requirements
- R1: When `rst` is high at a clock edge, the level register becomes 0x0000, so `pin_out` is 0 after that edge.
- R2: A write to offset 0x0 loads `bus_wdata[15:0]` into the level register on that edge. Bits 31:16 of the write are dropped.
- R3: A read of offset 0x0 returns the level register in bits 15:0, with bits 31:16 reading as zero.
- R4: A write to offset 0x4 (the set/clear word) sets pin n when `bus_wdata[n]` is 1 and clears pin n when `bus_wdata[n+16]` is 1. Pins whose two bits are both 0 keep their level. All of these changes land on the same edge.
- R5: In a set/clear write that has both `bus_wdata[n]` and `bus_wdata[n+16]` at 1, pin n ends at 1.
- R6: A write to offset 0x8 (the clear-only word) clears pin n when `bus_wdata[n]` is 1 and leaves pins with a 0 unchanged. Bits 31:16 of this write have no effect.
- R7: A set/clear write of 0xFFFF0000 OR'd with a 16-bit pattern P leaves `pin_out` equal to P after one edge.
- R8: `bus_rdata` is zero for reads of 0x4, 0x8 and any unmapped address, and zero whenever `bus_re` is low.
- R9: Writes to unmapped addresses (anything other than 0x0, 0x4 or 0x8, including addresses that are not word-aligned) leave `pin_out` unchanged.
- R10: In a cycle with `bus_we` low, `pin_out` holds its value across the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data word |
| bus_we | input | 1 | Write enable, acted on at the rising edge |
| bus_re | input | 1 | Read enable, qualifies `bus_rdata` in the same cycle |
| bus_rdata | output | 32 | Read data, zero when not reading a readable register |
| pin_out | output | 16 | Pin levels, driven directly by the level register |

## Verification
The assertions assume that `bus_we` and `bus_re` are never X, that write data and address are stable around the rising edge, and that reset is held for at least one edge before checking starts. The pin properties compare the pins after an edge with the write word of the previous cycle. For that reason they need a whole, non-reset cycle between the write and the check. The bench drives every input on the falling edge and holds it through the next rising edge. It raises only one of `bus_we` and `bus_re` at a time and checks the pins and read data on the following falling edge. This keeps every access inside these assumptions.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int unsigned PIN_COUNT  = 16;
  localparam int unsigned BUS_WORD_W = 32;
  localparam int unsigned BUS_ADDR_W = 4;

  localparam logic [BUS_ADDR_W-1:0] OFS_LEVEL    = 4'h0;
  localparam logic [BUS_ADDR_W-1:0] OFS_SETCLR   = 4'h4;
  localparam logic [BUS_ADDR_W-1:0] OFS_CLRONLY  = 4'h8;

  typedef enum logic [1:0] {
    REG_NONE    = 2'd0,
    REG_LEVEL   = 2'd1,
    REG_SETCLR  = 2'd2,
    REG_CLRONLY = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_addr_decode.sv
module pin_addr_decode
  import pin_port_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_LEVEL))        sel = REG_LEVEL;
    else if (addr == ADDR_W'(OFS_SETCLR))  sel = REG_SETCLR;
    else if (addr == ADDR_W'(OFS_CLRONLY)) sel = REG_CLRONLY;
    else                                   sel = REG_NONE;
  end

  // R9
  always_comb begin
    unaligned_none_chk: assert (addr[1:0] == 2'b00 || sel == REG_NONE);
  end
endmodule

// File: rtl/pin_bit_update.sv
module pin_bit_update
  import pin_port_pkg::*;
#(
  parameter int unsigned PINS   = PIN_COUNT,
  parameter int unsigned WORD_W = BUS_WORD_W
) (
  input  logic [PINS-1:0]   cur,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  output logic [PINS-1:0]   nxt
);
  localparam int unsigned CLR_BASE = WORD_W / 2;

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    logic set_hit;
    logic clr_hit;

    always_comb begin
      set_hit = 1'b0;
      clr_hit = 1'b0;
      if (wr_en) begin
        unique case (sel)
          REG_SETCLR: begin
            set_hit = wdata[i];
            clr_hit = wdata[CLR_BASE + i];
          end
          REG_CLRONLY: clr_hit = wdata[i];
          default: ;
        endcase
      end
    end

    always_comb begin
      if (wr_en && sel == REG_LEVEL) nxt[i] = wdata[i];
      else if (set_hit)              nxt[i] = 1'b1;
      else if (clr_hit)              nxt[i] = 1'b0;
      else                           nxt[i] = cur[i];
    end
  end

  // R9
  always_comb begin
    idle_hold_chk: assert (!(wr_en && sel == REG_NONE) || nxt == cur);
  end
endmodule

// File: rtl/pin_read_mux.sv
module pin_read_mux
  import pin_port_pkg::*;
#(
  parameter int unsigned PINS   = PIN_COUNT,
  parameter int unsigned WORD_W = BUS_WORD_W
) (
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [PINS-1:0]   level,
  output logic [WORD_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en && sel == REG_LEVEL) rdata[PINS-1:0] = level;
  end
endmodule

// File: rtl/pin_drive_port.sv
module pin_drive_port
  import pin_port_pkg::*;
#(
  parameter int unsigned PINS   = PIN_COUNT,
  parameter int unsigned WORD_W = BUS_WORD_W,
  parameter int unsigned ADDR_W = BUS_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [PINS-1:0]   pin_out
);
  localparam int unsigned HALF = WORD_W / 2;

  reg_sel_e        sel;
  logic [PINS-1:0] level_q;
  logic [PINS-1:0] level_d;

  pin_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  pin_bit_update #(.PINS(PINS), .WORD_W(WORD_W)) u_upd (
    .cur   (level_q),
    .wdata (bus_wdata),
    .wr_en (bus_we),
    .sel   (sel),
    .nxt   (level_d)
  );

  pin_read_mux #(.PINS(PINS), .WORD_W(WORD_W)) u_rd (
    .rd_en (bus_re),
    .sel   (sel),
    .level (level_q),
    .rdata (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  assign pin_out = level_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> pin_out == '0);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_SETCLR) |=>
      ((pin_out & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

  // R4
  clear_half_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_SETCLR) |=>
      ((pin_out & $past(bus_wdata[HALF+PINS-1:HALF]) & ~$past(bus_wdata[PINS-1:0])) == '0));

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_CLRONLY) |=> ((pin_out & $past(bus_wdata[PINS-1:0])) == '0));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_out));

  // R8
  read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_re || sel != REG_LEVEL) |-> bus_rdata == '0);

  // R3
  read_level_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && sel == REG_LEVEL) |-> bus_rdata == WORD_W'(pin_out));
endmodule

// File: tb/sim_pin_drive_port.sv
module sim_pin_drive_port;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [15:0] pin_out;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_drive_port u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_out(pin_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1", {16'h0, pin_out}, 32'h0);
    rd(4'h0, d);
    check("R3", d, 32'h0);
  endtask

  task automatic t_direct;
    logic [31:0] d;
    wr(4'h0, 32'hABCD_1234);
    check("R2", {16'h0, pin_out}, 32'h1234);
    rd(4'h0, d);
    check("R3", d, 32'h0000_1234);
  endtask

  task automatic t_setclr;
    wr(4'h0, 32'h0000_0040);
    wr(4'h4, 32'h0040_0080);
    check("R4", {16'h0, pin_out}, 32'h0080);
    wr(4'h0, 32'h0000_F0F0);
    wr(4'h4, 32'h00F0_0100);
    check("R4", {16'h0, pin_out}, 32'hF100);
  endtask

  task automatic t_setwins;
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0003_0003);
    check("R5", {16'h0, pin_out}, 32'h0003);
    wr(4'h0, 32'hFFFF);
    wr(4'h4, 32'h8001_8000);
    check("R5", {16'h0, pin_out}, 32'hFFFE);
  endtask

  task automatic t_clronly;
    wr(4'h0, 32'hFFFF);
    wr(4'h8, 32'hFFFF_00F0);
    check("R6", {16'h0, pin_out}, 32'hFF0F);
  endtask

  task automatic t_pattern;
    wr(4'h0, 32'h5A5A);
    wr(4'h4, 32'hFFFF_1234);
    check("R7", {16'h0, pin_out}, 32'h1234);
    wr(4'h4, 32'hFFFF_0000);
    check("R7", {16'h0, pin_out}, 32'h0000);
  endtask

  task automatic t_reads;
    logic [31:0] d;
    wr(4'h0, 32'h00FF);
    rd(4'h4, d); check("R8", d, 32'h0);
    rd(4'h8, d); check("R8", d, 32'h0);
    rd(4'hC, d); check("R8", d, 32'h0);
    rd(4'h1, d); check("R8", d, 32'h0);
    @(negedge clk);
    bus_addr = 4'h0; bus_re = 1'b0;
    #2 check("R8", bus_rdata, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(4'h0, 32'h00FF);
    wr(4'hC, 32'hFFFF_FFFF);
    check("R9", {16'h0, pin_out}, 32'h00FF);
    wr(4'h1, 32'hFFFF_0000);
    check("R9", {16'h0, pin_out}, 32'h00FF);
    wr(4'h5, 32'hFFFF_0000);
    check("R9", {16'h0, pin_out}, 32'h00FF);
  endtask

  task automatic t_idle;
    wr(4'h0, 32'h3C3C);
    @(negedge clk);
    bus_addr = 4'h0; bus_wdata = 32'h0000_FFFF; bus_we = 1'b0;
    @(negedge clk);
    check("R10", {16'h0, pin_out}, 32'h3C3C);
    bus_addr = 4'h4; bus_wdata = 32'hFFFF_0000;
    @(negedge clk);
    check("R10", {16'h0, pin_out}, 32'h3C3C);
    bus_wdata = '0;
  endtask

  task automatic t_reset_mid;
    wr(4'h0, 32'hFFFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", {16'h0, pin_out}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direct();
    t_setclr();
    t_setwins();
    t_clronly();
    t_pattern();
    t_reads();
    t_unmapped();
    t_idle();
    t_reset_mid();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule